// File: doc/BRIEF.md
# Paged Outbound Address Translation Table

This block maps addresses from an internal memory-mapped bus into a wider external address space, such as a PCI Express 64-bit space. It keeps the low offset bits of each incoming address. It replaces everything above the offset with an upper-address value taken from a small page table. A field just above the offset picks one of the table's entries. Each entry also says whether the translated address is a 32-bit or a 64-bit external address.

The table is loaded at run time through a simple register port. This is needed because external address windows are only known after the system has been brought up. The translation side takes an address with a valid strobe. One clock later it returns the translated address, the 32/64-bit flag and a valid strobe. Address bits above the page-select field are used by the interconnect to pick this block, so the block ignores them.

In the default build there are 16 pages of 1 MByte each. That means 20 offset bits and 4 page-select bits.

Top module: `axt_top`

## Requirements
- R1: While reset is held low and right after it is released, `xl_valid_o`, `xl_addr_o`, `xl_is64_o`, `reg_rvalid_o` and `reg_rdata_o` are zero. Every table word reads back as zero until it is written.
- R2: Bits [23:20] of `xl_addr_i` select the table entry. Bits [19:0] appear unchanged on `xl_addr_o[19:0]`.
- R3: Bits [31:24] of `xl_addr_i` have no effect on the translated result.
- R4: When the selected entry has its size flag set (1 = 64-bit), `xl_is64_o` is 1. In that case `xl_addr_o[63:32]` equals the entry's high word and `xl_addr_o[31:20]` equals bits [31:20] of its low word.
- R5: When the selected entry's size flag is 0 (32-bit), `xl_is64_o` is 0 and `xl_addr_o[63:32]` is zero. Bits [31:20] still come from the low word.
- R6: `xl_valid_o` is high exactly in the cycle after a cycle with `xl_valid_i` high. `xl_addr_o` and `xl_is64_o` belong to that input.
- R7: Register map: `reg_addr_i[0]` picks the word (0 = low word, 1 = high word) and `reg_addr_i[4:1]` picks the entry. A write takes place in a cycle with `reg_wr_i` high. The low word keeps bits [31:20] as upper address and bit 0 as the size flag. The high word keeps all 32 bits.
- R8: A translation presented in the cycle after a table write sees the new value. A translation presented in the same cycle as the write sees the old value.
- R9: A read in a cycle with `reg_rd_i` high returns the addressed word on `reg_rdata_o` with `reg_rvalid_o` high in the next cycle. A read in the same cycle as a write to that word returns the value from before the write.
- R10: Low-word bits [19:1] are not stored and always read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_valid_i | input | 1 | Incoming address is valid |
| xl_addr_i | input | 32 | Internal bus address |
| xl_valid_o | output | 1 | Translated address is valid |
| xl_addr_o | output | 64 | Translated external address |
| xl_is64_o | output | 1 | 1 = 64-bit external address, 0 = 32-bit |
| reg_wr_i | input | 1 | Table write strobe |
| reg_rd_i | input | 1 | Table read strobe |
| reg_addr_i | input | 5 | Word select (bit 0) and entry index (bits 4:1) |
| reg_wdata_i | input | 32 | Table write data |
| reg_rdata_o | output | 32 | Table read data |
| reg_rvalid_o | output | 1 | Read data is valid |

## Verification
A corrupted or stale entry appears on the first translation that selects that page, one cycle after it is presented. Depending on the fault, it shows up as wrong upper bits, a wrong size flag, or non-zero bits [63:32] on a 32-bit page. The same entry also reads back wrong through the register port one cycle after the read strobe. A fault in the write ordering shows up only in the cycle right after a write, or in the same cycle as a write, so the bench compares every cycle rather than only settled states. The bench also puts random values on the ignored top address bits and on the unstored low-word bits, so that a decode that wrongly uses them changes the translated address or the read-back value.

// File: rtl/axt_pkg.sv
// Package: shared encodings for the paged outbound address translator.
// Assumes a register word width of 32 bits and a 64-bit external space.
package axt_pkg;
    localparam int REG_W = 32;
    localparam int EXT_W = 64;

    // Address size chosen per table entry
    typedef enum logic {
        SIZE_32 = 1'b0,
        SIZE_64 = 1'b1
    } addr_size_e;

    // Word select within one entry on the register port
    typedef enum logic {
        WORD_LO = 1'b0,
        WORD_HI = 1'b1
    } word_sel_e;
endpackage

// File: rtl/axt_table.sv
// Module: page table storage with one write port, one lookup port for
// translation and one read port for the register interface.
// Lookups and reads are combinational on the stored state, so a write
// becomes visible to both ports from the following cycle.
// Assumes 2 <= OFF_W < 32.
module axt_table
    import axt_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int OFF_W  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_W-1:0]    wr_entry,
    input  logic                 wr_hi_sel,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [PAGE_W-1:0]    lk_entry,
    output logic [REG_W-1:0]     lk_hi,
    output logic [REG_W-OFF_W-1:0] lk_upper,
    output logic                 lk_is64,
    input  logic [PAGE_W-1:0]    rd_entry,
    input  logic                 rd_hi_sel,
    output logic [REG_W-1:0]     rd_word
);
    localparam int ENTRIES = 1 << PAGE_W;
    localparam int UP_W    = REG_W - OFF_W;

    logic [REG_W-1:0] hi_q   [ENTRIES];
    logic [UP_W-1:0]  up_q   [ENTRIES];
    logic             size_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [REG_W-1:0] hi_r;
        logic [UP_W-1:0]  up_r;
        logic             size_r;

        // Clear on reset; take a write aimed at this entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_r   <= '0;
                up_r   <= '0;
                size_r <= SIZE_32;
            end else if (wr_en && (wr_entry == PAGE_W'(g))) begin
                if (wr_hi_sel == WORD_HI) begin
                    hi_r <= wr_data;
                end else begin
                    up_r   <= wr_data[REG_W-1:OFF_W];
                    size_r <= wr_data[0];
                end
            end
        end

        assign hi_q[g]   = hi_r;
        assign up_q[g]   = up_r;
        assign size_q[g] = size_r;
    end

    // Translation lookup of the selected page
    always_comb begin
        lk_hi    = hi_q[lk_entry];
        lk_upper = up_q[lk_entry];
        lk_is64  = size_q[lk_entry];
    end

    // Register read view; unstored low-word bits read as zero
    always_comb begin
        if (rd_hi_sel == WORD_HI) begin
            rd_word = hi_q[rd_entry];
        end else begin
            rd_word = {up_q[rd_entry], {(OFF_W-1){1'b0}}, size_q[rd_entry]};
        end
    end
endmodule

// File: rtl/axt_xlate.sv
// Module: one-stage translation register. It builds the external address
// from the looked-up entry and the passed-through offset.
// Assumes the lookup inputs belong to the address presented this cycle.
module axt_xlate
    import axt_pkg::*;
#(
    parameter int OFF_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [OFF_W-1:0]       in_offset,
    input  logic [REG_W-1:0]       lk_hi,
    input  logic [REG_W-OFF_W-1:0] lk_upper,
    input  logic                   lk_is64,
    output logic                   out_valid,
    output logic [EXT_W-1:0]       out_addr,
    output logic                   out_is64
);
    logic [REG_W-1:0] top_word;

    // Upper word is zero for 32-bit pages
    always_comb begin
        top_word = (lk_is64 == SIZE_64) ? lk_hi : '0;
    end

    // Register the valid strobe every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Capture the translated address for a valid input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_is64 <= 1'b0;
        end else if (in_valid) begin
            out_addr <= {top_word, lk_upper, in_offset};
            out_is64 <= lk_is64;
        end
    end
endmodule

// File: rtl/axt_rdport.sv
// Module: registered read-data stage for the register port.
// Assumes the word input reflects the table before any write in the same cycle.
module axt_rdport
    import axt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [REG_W-1:0] rd_word,
    output logic [REG_W-1:0] rdata,
    output logic             rvalid
);
    // Return the addressed word one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= rd_word;
            end
        end
    end
endmodule

// File: rtl/axt_top.sv
// Module: paged outbound address translator. It splits the internal address
// into page index and offset, and decodes the register port into entry and word.
// Address bits above the page index are used by upstream slave selection
// and are deliberately left unused here.
module axt_top
    import axt_pkg::*;
#(
    parameter int IN_AW  = 32,
    parameter int OFF_W  = 20,
    parameter int PAGE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xl_valid_i,
    input  logic [IN_AW-1:0]    xl_addr_i,
    output logic                xl_valid_o,
    output logic [EXT_W-1:0]    xl_addr_o,
    output logic                xl_is64_o,
    input  logic                reg_wr_i,
    input  logic                reg_rd_i,
    input  logic [PAGE_W:0]     reg_addr_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    output logic                reg_rvalid_o
);
    localparam int UP_W = REG_W - OFF_W;

    logic [PAGE_W-1:0] page_idx;
    logic [OFF_W-1:0]  page_off;
    logic [PAGE_W-1:0] reg_entry;
    logic              reg_hi_sel;
    logic [REG_W-1:0]  lk_hi;
    logic [UP_W-1:0]   lk_upper;
    logic              lk_is64;
    logic [REG_W-1:0]  rd_word;

    // Split incoming address and register address
    always_comb begin
        page_idx   = xl_addr_i[OFF_W+PAGE_W-1:OFF_W];
        page_off   = xl_addr_i[OFF_W-1:0];
        reg_entry  = reg_addr_i[PAGE_W:1];
        reg_hi_sel = reg_addr_i[0];
    end

    axt_table #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_i),
        .wr_entry  (reg_entry),
        .wr_hi_sel (reg_hi_sel),
        .wr_data   (reg_wdata_i),
        .lk_entry  (page_idx),
        .lk_hi     (lk_hi),
        .lk_upper  (lk_upper),
        .lk_is64   (lk_is64),
        .rd_entry  (reg_entry),
        .rd_hi_sel (reg_hi_sel),
        .rd_word   (rd_word)
    );

    axt_xlate #(.OFF_W(OFF_W)) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (xl_valid_i),
        .in_offset (page_off),
        .lk_hi     (lk_hi),
        .lk_upper  (lk_upper),
        .lk_is64   (lk_is64),
        .out_valid (xl_valid_o),
        .out_addr  (xl_addr_o),
        .out_is64  (xl_is64_o)
    );

    axt_rdport u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (reg_rd_i),
        .rd_word (rd_word),
        .rdata   (reg_rdata_o),
        .rvalid  (reg_rvalid_o)
    );
endmodule

// File: rtl/axt_checker.sv
// Module: protocol and format properties of the translator, bound to axt_top.
module axt_checker #(
    parameter int IN_AW  = 32,
    parameter int OFF_W  = 20,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xl_valid_i,
    input logic [IN_AW-1:0]  xl_addr_i,
    input logic              xl_valid_o,
    input logic [63:0]       xl_addr_o,
    input logic              xl_is64_o,
    input logic              reg_rd_i,
    input logic [PAGE_W:0]   reg_addr_i,
    input logic [31:0]       reg_rdata_o,
    input logic              reg_rvalid_o
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid_i |=> xl_valid_o);  // R6
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid_i |=> !xl_valid_o);  // R6
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid_i |=> (xl_addr_o[OFF_W-1:0] == $past(xl_addr_i[OFF_W-1:0])));  // R2
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_valid_o && !xl_is64_o) |-> (xl_addr_o[63:32] == 32'h0));  // R5
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_i |=> reg_rvalid_o);  // R9
    AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> !reg_rvalid_o);  // R9
    AST_LOW_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && !reg_addr_i[0]) |=> (reg_rdata_o[OFF_W-1:1] == '0));  // R10
endmodule

bind axt_top axt_checker #(.IN_AW(IN_AW), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_axt_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xl_valid_i   (xl_valid_i),
    .xl_addr_i    (xl_addr_i),
    .xl_valid_o   (xl_valid_o),
    .xl_addr_o    (xl_addr_o),
    .xl_is64_o    (xl_is64_o),
    .reg_rd_i     (reg_rd_i),
    .reg_addr_i   (reg_addr_i),
    .reg_rdata_o  (reg_rdata_o),
    .reg_rvalid_o (reg_rvalid_o)
);

// File: tb/tb_axt_top.sv
module tb_axt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_valid_i = 1'b0;
    logic [31:0] xl_addr_i = '0;
    logic        xl_valid_o;
    logic [63:0] xl_addr_o;
    logic        xl_is64_o;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [4:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        reg_rvalid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model of the table: stored low and high words
    logic [31:0] m_lo [16];
    logic [31:0] m_hi [16];

    logic        e_valid, e_is64, e_rvalid;
    logic [63:0] e_addr;
    logic [31:0] e_rdata;

    always #2 clk = ~clk;

    axt_top dut (
        .clk(clk), .rst_n(rst_n),
        .xl_valid_i(xl_valid_i), .xl_addr_i(xl_addr_i),
        .xl_valid_o(xl_valid_o), .xl_addr_o(xl_addr_o), .xl_is64_o(xl_is64_o),
        .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .reg_rvalid_o(reg_rvalid_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, predict at the edge, compare after the edge
    task automatic step(input bit v, input logic [31:0] a, input bit w, input bit r,
                        input logic [4:0] ra, input logic [31:0] wd, input string tag);
        int ent;
        int rent;
        xl_valid_i = v; xl_addr_i = a; reg_wr_i = w; reg_rd_i = r;
        reg_addr_i = ra; reg_wdata_i = wd;
        @(posedge clk);
        ent = int'(a[23:20]);
        rent = int'(ra[4:1]);
        e_valid = v;
        if (v) begin
            e_is64 = m_lo[ent][0];
            e_addr = {(e_is64 ? m_hi[ent] : 32'h0), m_lo[ent][31:20], a[19:0]};
        end
        e_rvalid = r;
        if (r) e_rdata = ra[0] ? m_hi[rent] : m_lo[rent];
        if (w) begin
            if (ra[0]) m_hi[rent] = wd;
            else       m_lo[rent] = {wd[31:20], 19'h0, wd[0]};
        end
        @(negedge clk);
        chk(xl_valid_o === e_valid, "R6 valid", 64'(xl_valid_o), 64'(e_valid));
        if (e_valid) begin
            chk(xl_addr_o === e_addr, tag, xl_addr_o, e_addr);
            chk(xl_is64_o === e_is64, tag, 64'(xl_is64_o), 64'(e_is64));
        end
        chk(reg_rvalid_o === e_rvalid, "R9 rvalid", 64'(reg_rvalid_o), 64'(e_rvalid));
        if (e_rvalid) chk(reg_rdata_o === e_rdata, tag, 64'(reg_rdata_o), 64'(e_rdata));
        xl_valid_i = 1'b0; reg_wr_i = 1'b0; reg_rd_i = 1'b0;
    endtask

    task automatic wr(input int e, input bit hi, input logic [31:0] d);
        step(1'b0, 32'h0, 1'b1, 1'b0, {e[3:0], hi}, d, "R7 write");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk(xl_valid_o === 1'b0 && xl_addr_o === 64'h0 && xl_is64_o === 1'b0, "R1 reset xl",
            xl_addr_o, 64'h0);
        chk(reg_rvalid_o === 1'b0 && reg_rdata_o === 32'h0, "R1 reset reg", 64'(reg_rdata_o), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xl_valid_o === 1'b0 && reg_rvalid_o === 1'b0, "R1 after release",
            64'({xl_valid_o, reg_rvalid_o}), 64'h0);
        // R1: every word reads zero after reset
        for (int i = 0; i < 32; i++) step(1'b0, 32'h0, 1'b0, 1'b1, 5'(i), 32'h0, "R1 table zero");
        // R7: program entries
        wr(3, 1'b0, 32'hABC0_0001);
        wr(3, 1'b1, 32'h1234_5678);
        wr(5, 1'b0, 32'h7FF0_0000);
        wr(5, 1'b1, 32'hDEAD_BEEF);
        wr(15, 1'b0, 32'hFFFF_FFFF);
        wr(15, 1'b1, 32'h0000_0001);
        // R2 R3 R4: 64-bit page with junk in the ignored top bits
        step(1'b1, 32'hFF31_2345, 1'b0, 1'b0, 5'h0, 32'h0, "R2 R3 R4 wide page");
        step(1'b1, 32'h0031_2345, 1'b0, 1'b0, 5'h0, 32'h0, "R3 top bits ignored");
        // R5: 32-bit page drives zero upper word
        step(1'b1, 32'h005A_BCDE, 1'b0, 1'b0, 5'h0, 32'h0, "R5 narrow page");
        step(1'b1, 32'hA5F0_0000, 1'b0, 1'b0, 5'h0, 32'h0, "R4 entry 15");
        // R10: unstored low-word bits read zero; R7 word map
        step(1'b0, 32'h0, 1'b0, 1'b1, {4'd15, 1'b0}, 32'h0, "R10 low word rsvd");
        step(1'b0, 32'h0, 1'b0, 1'b1, {4'd5, 1'b1}, 32'h0, "R7 high word read");
        // R6: back-to-back and gapped translations
        step(1'b1, 32'h0030_0001, 1'b0, 1'b0, 5'h0, 32'h0, "R6 b2b");
        step(1'b1, 32'h0050_0002, 1'b0, 1'b0, 5'h0, 32'h0, "R6 b2b");
        step(1'b0, 32'h0050_0003, 1'b0, 1'b0, 5'h0, 32'h0, "R6 gap");
        // R8: same-cycle write sees old, next cycle sees new
        step(1'b1, 32'h0051_1111, 1'b1, 1'b0, {4'd5, 1'b0}, 32'h1110_0001, "R8 same cycle old");
        step(1'b1, 32'h0051_1111, 1'b0, 1'b0, 5'h0, 32'h0, "R8 next cycle new");
        // R9: read in same cycle as a write to that word returns old
        step(1'b0, 32'h0, 1'b1, 1'b1, {4'd3, 1'b1}, 32'hCAFE_F00D, "R9 read during write");
        step(1'b0, 32'h0, 1'b0, 1'b1, {4'd3, 1'b1}, 32'h0, "R9 read after write");
        // Mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            step(1'($urandom), $urandom, 1'(($urandom % 4) == 0), 1'($urandom), 5'($urandom),
                 $urandom, "R2 R3 R4 R5 R8 R9 R10 random");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule